// File: doc/BRIEF.md
# Multi-Mode Timer Capture Channel

This block is one timer channel that a 7-bit mode field turns into one of three functions. It can be a general-purpose input that raises a flag on a chosen pin edge. It can be a general-purpose output whose level follows a configuration bit. It can also be a single-action capture unit, which latches the shared time-base counter value each time the chosen edge arrives. The pin input is already filtered and is synchronous to the channel clock. The counter value comes from an external time-base bus.

Software drives the channel through a small register port. The control word holds the mode, an edge polarity bit and an edge select bit. The status word holds the event flag and the sampled pin level. A third address reads back the capture register. Writing the control word with either GPIO mode resets the channel's internal state. Software is expected to pass through a GPIO mode whenever it changes between other modes. Each capture overwrites the previous one, and no read is needed in between.

Top module: `timer_chan`

## Requirements
- R1: While reset is high, and on the first clock after it, the mode, polarity and select bits, the flag, the capture register, `pin_out` and `rd_data` are all zero.
- R2: Control bits [6:0] select the mode: 0 is GPIO input, 1 is GPIO output, 2 is capture. Any other mode value never sets the flag, never changes the capture register, and holds `pin_out` at 0.
- R3: Control bit 9 (edge select) = 1 qualifies both edges. With bit 9 = 0, control bit 8 (polarity) = 1 qualifies only rising edges and 0 qualifies only falling edges. Edges are found by comparing the registered pin sample with the sample from the cycle before. A pin change sampled at clock k therefore acts at clock k+1.
- R4: In GPIO input mode a qualifying edge sets the flag. Status bit 1 reads back the registered pin sample.
- R5: In GPIO output mode `pin_out` equals the polarity bit, one clock after that bit and the mode are registered.
- R6: In capture mode a qualifying edge loads `cnt_bus` into the capture register and sets the flag on the same clock. Address 2 returns the capture register in bits [23:0].
- R7: Each later qualifying edge in capture mode overwrites the capture register and sets the flag again, with no read needed between events.
- R8: Writing 1 to status bit 0 (address 1) clears the flag. If a flag-setting edge and the clear fall on the same clock, the flag stays set.
- R9: A control write that selects mode 0 or 1 clears the flag and the capture register on that clock. It also ignores edges on the following clock.
- R10: After a write of capture mode that follows a GPIO mode, the first qualifying edge is captured with no extra arming step.
- R11: `rd_data` is registered one clock after `rd_addr`. The address map is: 0 for the control word (mode [6:0], polarity [8], select [9]), 1 for status (flag [0], pin level [1]), 2 for capture, and 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| cnt_bus | input | 24 | Selected time-base counter value |
| pin_in | input | 1 | Filtered channel input pin |
| pin_out | output | 1 | Channel output pin (registered) |
| flag_o | output | 1 | Channel event flag |

## Verification
The assertions assume that `pin_in` and `cnt_bus` are synchronous to `clk`. They also assume that software switches between non-GPIO modes only by way of a GPIO mode. Results for a direct change between non-GPIO modes are not defined. The stimulus always writes mode 0 before it sets up each new configuration. It drives the pin and counter only on falling clock edges, so every value is stable at the sampling edge.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int MODE_W  = 7;
  localparam int POL_BIT = 8;
  localparam int SEL_BIT = 9;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_CAPT = 2;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_PIN_BIT  = 1;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_GPI = 7'd0;
  localparam mode_t MODE_GPO = 7'd1;
  localparam mode_t MODE_CAP = 7'd2;
endpackage

// File: rtl/tc_edge_det.sv
module tc_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic pin_in,
  input  logic edge_pol,
  input  logic edge_both,
  output logic level,
  output logic rise_ev,
  output logic fall_ev,
  output logic qual
);
  logic smp_q;
  logic prev_q;
  logic hist_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q     <= 1'b0;
      prev_q    <= 1'b0;
      hist_ok_q <= 1'b0;
    end else begin
      smp_q     <= pin_in;
      prev_q    <= smp_q;
      hist_ok_q <= ~flush;
    end
  end

  assign level   = smp_q;
  assign rise_ev = hist_ok_q & smp_q & ~prev_q;
  assign fall_ev = hist_ok_q & ~smp_q & prev_q;

  always_comb begin
    if (edge_both) qual = rise_ev | fall_ev;
    else if (edge_pol) qual = rise_ev;
    else qual = fall_ev;
  end
endmodule

// File: rtl/tc_ctrl_regs.sv
module tc_ctrl_regs
  import tc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mode_t             mode_q,
  output logic              pol_q,
  output logic              both_q,
  output logic              gpio_wr,
  output logic              flag_clr
);
  logic ctrl_sel;
  logic stat_sel;
  logic unused_wr_bits;

  assign ctrl_sel = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign stat_sel = wr_en && (wr_addr == ADDR_W'(ADDR_STAT));

  assign gpio_wr  = ctrl_sel && ((wr_data[MODE_W-1:0] == MODE_GPI) ||
                                 (wr_data[MODE_W-1:0] == MODE_GPO));
  assign flag_clr = stat_sel && wr_data[STAT_FLAG_BIT];

  assign unused_wr_bits = ^{wr_data[DATA_W-1:SEL_BIT+1], wr_data[POL_BIT-1:MODE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_GPI;
      pol_q  <= 1'b0;
      both_q <= 1'b0;
    end else if (ctrl_sel) begin
      mode_q <= wr_data[MODE_W-1:0];
      pol_q  <= wr_data[POL_BIT];
      both_q <= wr_data[SEL_BIT];
    end
  end
endmodule

// File: rtl/tc_capture.sv
module tc_capture #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             cap_en,
  input  logic             flag_en,
  input  logic             qual,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] cnt_bus,
  output logic [CNT_W-1:0] a2_q,
  output logic             flag_q
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      a2_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (qual && cap_en) a2_q <= cnt_bus;
      if (qual && flag_en) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import tc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt_bus,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              flag_o
);
  mode_t            mode_q;
  logic             pol_q;
  logic             both_q;
  logic             gpio_wr;
  logic             flag_clr;
  logic             level;
  logic             rise_ev;
  logic             fall_ev;
  logic             qual;
  logic             cap_en;
  logic             flag_en;
  logic [CNT_W-1:0] a2_q;
  logic             flag_q;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] capt_word;

  tc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .pol_q(pol_q), .both_q(both_q),
    .gpio_wr(gpio_wr), .flag_clr(flag_clr)
  );

  tc_edge_det u_edge (
    .clk(clk), .rst(rst), .flush(gpio_wr), .pin_in(pin_in),
    .edge_pol(pol_q), .edge_both(both_q),
    .level(level), .rise_ev(rise_ev), .fall_ev(fall_ev), .qual(qual)
  );

  assign cap_en  = (mode_q == MODE_CAP);
  assign flag_en = (mode_q == MODE_CAP) || (mode_q == MODE_GPI);

  tc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .flush(gpio_wr), .cap_en(cap_en), .flag_en(flag_en),
    .qual(qual), .flag_clr(flag_clr), .cnt_bus(cnt_bus),
    .a2_q(a2_q), .flag_q(flag_q)
  );

  assign flag_o = flag_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[MODE_W-1:0] = mode_q;
    ctrl_word[POL_BIT]    = pol_q;
    ctrl_word[SEL_BIT]    = both_q;
    stat_word = '0;
    stat_word[STAT_FLAG_BIT] = flag_q;
    stat_word[STAT_PIN_BIT]  = level;
    capt_word = '0;
    capt_word[CNT_W-1:0] = a2_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      pin_out <= 1'b0;
    end else begin
      pin_out <= (mode_q == MODE_GPO) ? pol_q : 1'b0;
      case (rd_addr)
        ADDR_W'(ADDR_CTRL): rd_data <= ctrl_word;
        ADDR_W'(ADDR_STAT): rd_data <= stat_word;
        ADDR_W'(ADDR_CAPT): rd_data <= capt_word;
        default:            rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tc_chk.sv
module tc_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [6:0]       mode,
  input logic             pol,
  input logic             sel,
  input logic             gpio_wr,
  input logic             flag_clr,
  input logic             qual,
  input logic             rise_ev,
  input logic             fall_ev,
  input logic [CNT_W-1:0] cnt_bus,
  input logic [CNT_W-1:0] a2,
  input logic             flag,
  input logic             pin_out
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!flag && a2 == '0 && !pin_out && mode == 7'd0));

  // R2
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode > 7'd2 && !gpio_wr) |=> ($stable(a2) && !$rose(flag) && !pin_out));

  // R3
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    (qual && !sel && pol) |-> (rise_ev && !fall_ev));

  // R3
  fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (qual && !sel && !pol) |-> (fall_ev && !rise_ev));

  // R5
  gpo_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 7'd1) |=> (pin_out == $past(pol)));

  // R6
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 7'd2 && qual && !gpio_wr) |=> (a2 == $past(cnt_bus) && flag));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr && !gpio_wr) |=> flag);

  // R9
  gpio_flush_chk: assert property (@(posedge clk) disable iff (rst)
    gpio_wr |=> (a2 == '0 && !flag && !qual));
endmodule

bind timer_chan tc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .pol(pol_q), .sel(both_q),
  .gpio_wr(gpio_wr), .flag_clr(flag_clr), .qual(qual),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .cnt_bus(cnt_bus),
  .a2(a2_q), .flag(flag_q), .pin_out(pin_out)
);

// File: tb/test_timer_chan.sv
module test_timer_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic [23:0] cnt_bus = 24'd0;
  logic        pin_in = 1'b0;
  logic        pin_out;
  logic        flag_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit cnt_run = 1'b1;
  bit done = 1'b0;
  logic [31:0] lf = 32'h1234_5678;

  always #4 clk = ~clk;

  timer_chan i_timer_chan (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_bus(cnt_bus),
    .pin_in(pin_in), .pin_out(pin_out), .flag_o(flag_o)
  );

  // behavioural reference model
  logic        m_s0, m_s1, m_hv, m_pol, m_sel, m_flag, m_pout;
  logic [6:0]  m_mode;
  logic [23:0] m_a2;
  logic [31:0] m_rd;
  logic        e_rise, e_fall, e_hit, g_wr, c_wr;

  always @(posedge clk) begin
    if (rst) begin
      m_s0 = 0; m_s1 = 0; m_hv = 0; m_pol = 0; m_sel = 0; m_flag = 0;
      m_pout = 0; m_mode = 0; m_a2 = 0; m_rd = 0;
    end else begin
      e_rise = m_hv && m_s0 && !m_s1;
      e_fall = m_hv && !m_s0 && m_s1;
      e_hit  = m_sel ? (e_rise || e_fall) : (m_pol ? e_rise : e_fall);
      g_wr   = wr_en && wr_addr == 2'd0 && wr_data[6:0] <= 7'd1;
      c_wr   = wr_en && wr_addr == 2'd1 && wr_data[0];
      case (rd_addr)
        2'd0:    m_rd = {22'd0, m_sel, m_pol, 1'b0, m_mode};
        2'd1:    m_rd = {30'd0, m_s0, m_flag};
        2'd2:    m_rd = {8'd0, m_a2};
        default: m_rd = 32'd0;
      endcase
      m_pout = (m_mode == 7'd1) ? m_pol : 1'b0;
      if (g_wr) begin
        m_flag = 0;
        m_a2 = 0;
      end else begin
        if (e_hit && m_mode == 7'd2) m_a2 = cnt_bus;
        if (e_hit && (m_mode == 7'd0 || m_mode == 7'd2)) m_flag = 1;
        else if (c_wr) m_flag = 0;
      end
      if (wr_en && wr_addr == 2'd0) begin
        m_mode = wr_data[6:0];
        m_pol  = wr_data[8];
        m_sel  = wr_data[9];
      end
      m_hv = !g_wr;
      m_s1 = m_s0;
      m_s0 = pin_in;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk("R3 model flag", {31'd0, flag_o}, {31'd0, m_flag});
      chk("R5 model pin_out", {31'd0, pin_out}, {31'd0, m_pout});
      chk("R11 model rd_data", rd_data, m_rd);
    end
  end

  function automatic logic [31:0] ctl(input logic [6:0] md, input logic p, input logic s);
    return {22'd0, s, p, 1'b0, md};
  endfunction

  task automatic rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
  endtask

  task automatic tick();
    @(negedge clk);
    if (cnt_run) cnt_bus = cnt_bus + 24'h000013;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic rand_phase(input logic [6:0] md, input logic p, input logic s, input int n);
    wr(2'd0, ctl(7'd0, p, s));
    wr(2'd0, ctl(md, p, s));
    for (int i = 0; i < n; i++) begin
      rnd();
      if (lf[1:0] == 2'b00) pin_in = ~pin_in;
      rd_addr = lf[9:8];
      if (lf[15:12] == 4'h0) begin
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd1;
      end else wr_en = 1'b0;
      tick();
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    repeat (4) tick();
    // R1: values while reset is held
    chk("R1 flag in reset", {31'd0, flag_o}, 32'd0);
    chk("R1 pin_out in reset", {31'd0, pin_out}, 32'd0);
    rst = 1'b0;
    cmp_on = 1'b1;
    rd_addr = 2'd0; tick();
    chk("R1 control after reset", rd_data, 32'd0);
    rd_addr = 2'd1; tick();
    chk("R1 status after reset", rd_data, 32'd0);
    rd_addr = 2'd2; tick();
    chk("R1 capture after reset", rd_data, 32'd0);

    // R10 / R6: capture right after leaving GPIO
    cnt_run = 1'b0;
    cnt_bus = 24'h001000;
    wr(2'd0, ctl(7'd0, 1'b1, 1'b0));
    wr(2'd0, ctl(7'd2, 1'b1, 1'b0));
    pin_in = 1'b1; tick(); tick();
    chk("R10 flag on first edge", {31'd0, flag_o}, 32'd1);
    rd_addr = 2'd2; tick();
    chk("R6 capture value", rd_data, 32'h0000_1000);
    // R3: falling edge ignored with rising polarity
    cnt_bus = 24'h001250;
    pin_in = 1'b0; tick(); tick(); tick();
    chk("R3 falling edge ignored", rd_data, 32'h0000_1000);
    // R7: next rising edge overwrites
    pin_in = 1'b1; tick(); tick(); tick();
    chk("R7 overwrite", rd_data, 32'h0000_1250);
    // R8: clear, then set wins over clear
    wr(2'd1, 32'd1);
    chk("R8 clear", {31'd0, flag_o}, 32'd0);
    cnt_bus = 24'h0016A0;
    pin_in = 1'b0; tick(); tick();
    pin_in = 1'b1; tick();
    wr(2'd1, 32'd1);
    chk("R8 set wins", {31'd0, flag_o}, 32'd1);
    tick();
    chk("R7 third capture", rd_data, 32'h0000_16A0);
    // R9: GPIO write flushes
    wr(2'd0, ctl(7'd0, 1'b1, 1'b0));
    chk("R9 flag cleared", {31'd0, flag_o}, 32'd0);
    tick();
    chk("R9 capture cleared", rd_data, 32'd0);
    // R2: unused mode code does nothing
    wr(2'd0, ctl(7'd5, 1'b1, 1'b1));
    pin_in = 1'b0; tick(); tick();
    pin_in = 1'b1; tick(); tick(); tick();
    chk("R2 no flag", {31'd0, flag_o}, 32'd0);
    chk("R2 no capture", rd_data, 32'd0);
    chk("R2 pin_out low", {31'd0, pin_out}, 32'd0);
    // R4: GPIO input level and flag
    wr(2'd0, ctl(7'd0, 1'b1, 1'b0));
    rd_addr = 2'd1;
    pin_in = 1'b0; tick(); tick();
    chk("R4 level low", {31'd0, rd_data[1]}, 32'd0);
    chk("R4 no flag on fall", {31'd0, flag_o}, 32'd0);
    pin_in = 1'b1; tick(); tick();
    chk("R4 level high", {31'd0, rd_data[1]}, 32'd1);
    chk("R4 flag on rise", {31'd0, flag_o}, 32'd1);
    // R3: both edges, falling captured
    cnt_bus = 24'h000500;
    wr(2'd0, ctl(7'd0, 1'b0, 1'b1));
    wr(2'd0, ctl(7'd2, 1'b0, 1'b1));
    pin_in = 1'b0; tick(); tick();
    rd_addr = 2'd2; tick();
    chk("R3 both-edge capture", rd_data, 32'h0000_0500);
    // R5: GPIO output follows polarity
    wr(2'd0, ctl(7'd1, 1'b1, 1'b0));
    tick();
    chk("R5 pin_out high", {31'd0, pin_out}, 32'd1);
    wr(2'd0, ctl(7'd1, 1'b0, 1'b0));
    tick();
    chk("R5 pin_out low", {31'd0, pin_out}, 32'd0);
    // R11: address map readback
    rd_addr = 2'd0; tick();
    chk("R11 control readback", rd_data, 32'd1);
    rd_addr = 2'd3; tick();
    chk("R11 unused address", rd_data, 32'd0);

    // randomised phases against the model
    cnt_run = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        rand_phase((m == 3) ? 7'd5 : 7'(m), c[0], c[1], 150);
      end
    end
    tick();
    done = 1'b1;
    summary();
  end
endmodule